// File: doc/BRIEF.md
# Write-Back Line Cache with Victim Queue

This block is a tiny fully associative data cache that sits between a byte-addressed processor port and a line-wide memory port. Loads and stores that hit complete without touching memory; a store marks its line as modified. A miss allocates a line, fetching the whole line from memory. Stores allocate too and are then merged into the fetched line.

When the chosen victim holds modified data, the whole line is copied into a small victim queue and written to memory later, in the background. The fill for the miss therefore does not wait behind that write. A miss whose line is still sitting in the queue takes its data from the queue entry rather than from memory, so stale memory contents are never read. When both a fill and a queued write want the single memory port, the fill wins. If the queue is full and another modified victim must be pushed, the miss waits until one queued write completes.

Top module: `wb_cache`

## Requirements
- R1: After reset every line is invalid and the queue is empty: `mem_req` and `cpu_done` are low, and the first access to any address is a miss.
- R2: A load miss issues exactly one memory read (`mem_we`=0) carrying the line tag `cpu_addr[4:1]`. It returns the requested item, and the line is then allocated unmodified. `cpu_done` is a single-cycle pulse per access.
- R3: A store that hits updates only the cached item and marks the line modified. It causes no memory transaction.
- R4: Replacing an unmodified line causes no memory write.
- R5: Replacing a modified line leads to exactly one memory write (`mem_we`=1) of the whole line under the victim's tag. Item at offset 0 sits in `mem_wdata[7:0]` and offset 1 in `[15:8]`. Request fields stay stable until `mem_done`.
- R6: The victim is an invalid line if one exists, lowest index first. Otherwise it is the least recently used line, where both hits and allocations count as use.
- R7: Queued lines are written to memory in the order they entered the queue, one at a time. Each entry is removed only when `mem_done` confirms its write.
- R8: The queue holds 2 lines. A miss whose victim is modified while the queue is full waits, with no `cpu_done` and no lost entry, until one queued write completes.
- R9: A miss to a line that is present in the queue installs that entry's data, using the newest matching entry, without a memory read.
- R10: When the port is free and a fill is waiting, the fill is issued before any queued write. A queued write starts only when no fill is pending or about to be requested.
- R11: Address bit 0 selects the item within a line, and bits 4:1 form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held with its fields until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 5 | Byte address: tag in [4:1], item offset in [0] |
| cpu_wdata | input | 8 | Store item |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Load result, valid with `cpu_done` |
| mem_req | output | 1 | Memory transaction request, held until `mem_done` |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_tag | output | 4 | Line address of the transaction |
| mem_wdata | output | 16 | Line being written |
| mem_rdata | input | 16 | Line returned by a read, valid with `mem_done` |
| mem_done | input | 1 | One-cycle completion of the current transaction |

## Verification
The hardest situation to reach is a full queue meeting a miss with a modified victim. Two back-to-back evictions normally drain one entry before the next fill can start. The bench therefore holds back write acknowledgements in its memory model. It then fills the second queue slot through a queue-served miss, which needs no memory port, and follows with a miss whose victim is modified. On release, the order of writes and reads in the model's transaction log shows ordering, fill priority and that no entry was lost.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        C_LOOK = 2'd0,
        C_FILL = 2'd1,
        C_DONE = 2'd2
    } cpu_state_e;

    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_FILL  = 2'd1,
        P_DRAIN = 2'd2
    } port_state_e;

endpackage

// File: rtl/wbc_match.sv
module wbc_match #(
    parameter int LINES = 2,
    parameter int TAG_W = 4,
    parameter int WAY_W = 1
) (
    input  logic [LINES-1:0]            valid,
    input  logic [LINES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int i = 0; i < LINES; i++) begin
            if (valid[i] && tags[i] == look_tag) begin
                hit     = 1'b1;
                hit_way = WAY_W'(i);
            end
        end
    end
endmodule

// File: rtl/wbc_lru.sv
module wbc_lru #(
    parameter int LINES = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [LINES-1:0] valid,
    output logic [WAY_W-1:0] victim
);
    // age 0 = most recent, LINES-1 = least recent; ages stay a permutation
    logic [WAY_W-1:0] age [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) age[i] <= WAY_W'(i);
        end else if (touch) begin
            for (int i = 0; i < LINES; i++) begin
                if (WAY_W'(i) == touch_way)
                    age[i] <= '0;
                else if (age[i] < age[touch_way])
                    age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!valid[i] && !found) begin
                victim = WAY_W'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < LINES; i++) begin
                if (age[i] == WAY_W'(LINES - 1)) victim = WAY_W'(i);
            end
        end
    end
endmodule

// File: rtl/wbc_evq.sv
module wbc_evq #(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [TAG_W-1:0]  head_tag,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic              empty,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0]  e_tag  [DEPTH];
    logic [DATA_W-1:0] e_data [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;

    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign head_tag  = e_tag[rd_ptr];
    assign head_data = e_data[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                e_tag[i]  <= '0;
                e_data[i] <= '0;
            end
        end else begin
            if (push) begin
                e_tag[wr_ptr]  <= push_tag;
                e_data[wr_ptr] <= push_data;
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
        end
    end

    // scan oldest to newest so the newest match wins
    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int idx;
            idx = int'(rd_ptr) + k;
            if (idx >= DEPTH) idx = idx - DEPTH;
            if (k < int'(count) && e_tag[idx] == look_tag) begin
                look_hit  = 1'b1;
                look_data = e_data[idx];
            end
        end
    end
endmodule

// File: rtl/wb_cache.sv
module wb_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int OFF_W  = 1,
    parameter int ITEM_W = 8,
    parameter int LINES  = 2,
    parameter int QDEPTH = 2
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  cpu_req,
    input  logic                                  cpu_we,
    input  logic [ADDR_W-1:0]                     cpu_addr,
    input  logic [ITEM_W-1:0]                     cpu_wdata,
    output logic                                  cpu_done,
    output logic [ITEM_W-1:0]                     cpu_rdata,
    output logic                                  mem_req,
    output logic                                  mem_we,
    output logic [ADDR_W-OFF_W-1:0]               mem_tag,
    output logic [(1<<OFF_W)*ITEM_W-1:0]          mem_wdata,
    input  logic [(1<<OFF_W)*ITEM_W-1:0]          mem_rdata,
    input  logic                                  mem_done
);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int ITEMS  = 1 << OFF_W;
    localparam int LINE_W = ITEMS * ITEM_W;
    localparam int WAY_W  = $clog2(LINES);

    cpu_state_e  cst;
    port_state_e pst;

    logic [LINES-1:0]            lv, ld;
    logic [LINES-1:0][TAG_W-1:0] lt;
    logic [LINE_W-1:0]           ldat [LINES];
    logic [ITEM_W-1:0]           rdata_q;
    logic [WAY_W-1:0]            fill_way;

    logic [TAG_W-1:0]  req_tag;
    logic [OFF_W-1:0]  req_off;
    logic              hit, look;
    logic [WAY_W-1:0]  hit_way, vic;
    logic              need_push, miss_go, look_hit_now;
    logic              q_push, q_pop, q_full, q_empty, q_hit;
    logic [TAG_W-1:0]  q_head_tag;
    logic [LINE_W-1:0] q_head_data, q_hit_data, merged;
    logic              touch, fill_done, fill_wait, port_idle;
    logic [WAY_W-1:0]  touch_way;

    assign req_tag = cpu_addr[ADDR_W-1:OFF_W];
    assign req_off = cpu_addr[OFF_W-1:0];

    wbc_match #(.LINES(LINES), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .valid(lv), .tags(lt), .look_tag(req_tag), .hit(hit), .hit_way(hit_way)
    );

    wbc_lru #(.LINES(LINES), .WAY_W(WAY_W)) u_lru (
        .clk(clk), .rst(rst), .touch(touch), .touch_way(touch_way),
        .valid(lv), .victim(vic)
    );

    wbc_evq #(.TAG_W(TAG_W), .DATA_W(LINE_W), .DEPTH(QDEPTH)) u_evq (
        .clk(clk), .rst(rst),
        .push(q_push), .push_tag(lt[vic]), .push_data(ldat[vic]),
        .pop(q_pop), .head_tag(q_head_tag), .head_data(q_head_data),
        .full(q_full), .empty(q_empty),
        .look_tag(req_tag), .look_hit(q_hit), .look_data(q_hit_data)
    );

    // access decisions in the lookup state
    always_comb begin
        look         = (cst == C_LOOK) && cpu_req;
        look_hit_now = look && hit;
        need_push    = lv[vic] && ld[vic];
        miss_go      = look && !hit && !(need_push && q_full);
        q_push       = miss_go && need_push;
        fill_done    = (pst == P_FILL) && mem_done;
        q_pop        = (pst == P_DRAIN) && mem_done;
        fill_wait    = (cst == C_FILL);
        port_idle    = (pst == P_IDLE);
        merged       = ldat[hit_way];
        merged[int'(req_off)*ITEM_W +: ITEM_W] = cpu_wdata;
        touch        = look_hit_now || (miss_go && q_hit) || fill_done;
        touch_way    = look_hit_now ? hit_way : (fill_done ? fill_way : vic);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cst      <= C_LOOK;
            lv       <= '0;
            ld       <= '0;
            lt       <= '0;
            fill_way <= '0;
            rdata_q  <= '0;
            for (int i = 0; i < LINES; i++) ldat[i] <= '0;
        end else begin
            case (cst)
                C_LOOK: begin
                    if (look_hit_now) begin
                        rdata_q <= ldat[hit_way][int'(req_off)*ITEM_W +: ITEM_W];
                        if (cpu_we) begin
                            ldat[hit_way] <= merged;
                            ld[hit_way]   <= 1'b1;
                        end
                        cst <= C_DONE;
                    end else if (miss_go) begin
                        ld[vic] <= 1'b0;
                        if (q_hit) begin
                            lv[vic]   <= 1'b1;
                            lt[vic]   <= req_tag;
                            ldat[vic] <= q_hit_data;
                        end else begin
                            lv[vic]  <= 1'b0;
                            fill_way <= vic;
                            cst      <= C_FILL;
                        end
                    end
                end
                C_FILL: begin
                    if (fill_done) begin
                        lv[fill_way]   <= 1'b1;
                        ld[fill_way]   <= 1'b0;
                        lt[fill_way]   <= req_tag;
                        ldat[fill_way] <= mem_rdata;
                        cst            <= C_LOOK;
                    end
                end
                default: cst <= C_LOOK;
            endcase
        end
    end

    // single memory port: fill first, queued writes only when no fill is near
    always_ff @(posedge clk) begin
        if (rst) begin
            pst <= P_IDLE;
        end else begin
            case (pst)
                P_IDLE: begin
                    if (fill_wait)
                        pst <= P_FILL;
                    else if (!q_empty && !miss_go)
                        pst <= P_DRAIN;
                end
                P_FILL, P_DRAIN: if (mem_done) pst <= P_IDLE;
                default: pst <= P_IDLE;
            endcase
        end
    end

    assign mem_req   = (pst != P_IDLE);
    assign mem_we    = (pst == P_DRAIN);
    assign mem_tag   = (pst == P_FILL) ? req_tag : q_head_tag;
    assign mem_wdata = q_head_data;
    assign cpu_done  = (cst == C_DONE);
    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
    parameter int TAG_W  = 4,
    parameter int LINE_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_done,
    input logic [TAG_W-1:0]  mem_tag,
    input logic [LINE_W-1:0] mem_wdata,
    input logic              q_push,
    input logic              q_full,
    input logic              q_empty,
    input logic              fill_wait,
    input logic              port_idle
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_req && !cpu_done));

    a_r2_done_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    a_r5_write_has_entry: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !q_empty);

    a_r5_line_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !mem_done) |=> $stable(mem_wdata));

    a_r7_request_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_we) && $stable(mem_tag)));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        q_push |-> !q_full);

    a_r10_fill_first: assert property (@(posedge clk) disable iff (rst)
        (port_idle && fill_wait) |=> (mem_req && !mem_we));
endmodule

bind wb_cache wbc_cache_chk #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst(rst), .cpu_done(cpu_done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_done(mem_done), .mem_tag(mem_tag),
    .mem_wdata(mem_wdata), .q_push(q_push), .q_full(q_full),
    .q_empty(q_empty), .fill_wait(fill_wait), .port_idle(port_idle)
);

// File: tb/test_wb_cache.sv
`timescale 1ns/1ps
module test_wb_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [4:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_done;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we;
    logic [3:0]  mem_tag;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_done = 1'b0;

    int checks = 0, failures = 0;
    logic hold_wr = 1'b0;
    logic [15:0] mem [16];
    logic        log_we   [64];
    logic [3:0]  log_tag  [64];
    logic [15:0] log_data [64];
    int log_n = 0;

    always #2 clk = ~clk;

    wb_cache i_wb_cache (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_tag(mem_tag), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_done(mem_done)
    );

    // memory model with a transaction log and a write hold-off
    initial begin
        for (int t = 0; t < 16; t++) mem[t] = {4'(t), 4'h1, 4'(t), 4'h0};
        forever begin
            @(negedge clk);
            mem_done = 1'b0;
            if (mem_req && !rst) begin
                logic        w;
                logic [3:0]  t;
                logic [15:0] d;
                w = mem_we; t = mem_tag; d = mem_wdata;
                if (w) while (hold_wr) @(negedge clk);
                repeat (2) @(negedge clk);
                if (w) mem[t] = d; else mem_rdata = mem[t];
                log_we[log_n] = w; log_tag[log_n] = t; log_data[log_n] = w ? d : mem[t];
                log_n++;
                mem_done = 1'b1;
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL [watchdog] run did not complete: actual=hung expected=done");
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL [%s] %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_log(input int idx, input bit we, input logic [3:0] tag,
                           input logic [15:0] data, input string req);
        chk(idx < log_n, req, "log entry present", log_n, idx + 1);
        if (idx < log_n) begin
            chk(log_we[idx] == we, req, "transaction kind", log_we[idx], we);
            chk(log_tag[idx] == tag, req, "transaction tag", log_tag[idx], tag);
            chk(log_data[idx] == data, req, "transaction line", log_data[idx], data);
        end
    endtask

    task automatic access(input bit we, input logic [3:0] tag, input bit off,
                          input logic [7:0] wd, output logic [7:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = {tag, off}; cpu_wdata = wd;
        do @(negedge clk); while (!cpu_done);
        rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] rd;
        chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        chk(cpu_done == 1'b0, "R1", "cpu_done after reset", cpu_done, 0);
        access(1'b0, 4'h1, 1'b0, 8'h00, rd);
        chk(log_n == 1, "R1", "first access misses", log_n, 1);
        chk_log(0, 1'b0, 4'h1, 16'h1110, "R2");
        chk(rd == 8'h10, "R2", "load miss data", rd, 8'h10);
    endtask

    task automatic t_hits();
        logic [7:0] rd;
        access(1'b0, 4'h1, 1'b1, 8'h00, rd);
        chk(rd == 8'h11, "R11", "offset 1 item", rd, 8'h11);
        access(1'b1, 4'h1, 1'b0, 8'hA5, rd);
        access(1'b0, 4'h1, 1'b0, 8'h00, rd);
        chk(rd == 8'hA5, "R3", "store hit readback", rd, 8'hA5);
        settle();
        chk(log_n == 1, "R3", "store hit no memory traffic", log_n, 1);
    endtask

    task automatic t_replace();
        logic [7:0] rd;
        access(1'b0, 4'h2, 1'b1, 8'h00, rd);
        chk(rd == 8'h21, "R6", "second line uses invalid slot", rd, 8'h21);
        access(1'b0, 4'h1, 1'b1, 8'h00, rd);
        chk(log_n == 2, "R6", "first line kept", log_n, 2);
        access(1'b0, 4'h3, 1'b0, 8'h00, rd);
        settle();
        chk(log_n == 3, "R4", "clean victim no write", log_n, 3);
        chk_log(2, 1'b0, 4'h3, 16'h3130, "R6");
        access(1'b0, 4'h1, 1'b0, 8'h00, rd);
        chk(rd == 8'hA5 && log_n == 3, "R6", "recently used line retained", rd, 8'hA5);
        access(1'b0, 4'h4, 1'b0, 8'h00, rd);
        access(1'b0, 4'h5, 1'b0, 8'h00, rd);
        chk(rd == 8'h50, "R2", "tag 5 load", rd, 8'h50);
        settle();
        chk_log(3, 1'b0, 4'h4, 16'h4140, "R4");
        chk_log(4, 1'b0, 4'h5, 16'h5150, "R10");
        chk_log(5, 1'b1, 4'h1, 16'h11A5, "R5");
        chk(log_n == 6, "R5", "single write for dirty victim", log_n, 6);
    endtask

    task automatic t_queue();
        logic [7:0] rd;
        int base;
        bit seen;
        access(1'b1, 4'h4, 1'b0, 8'h4C, rd);
        access(1'b1, 4'h5, 1'b1, 8'h5D, rd);
        hold_wr = 1'b1;
        access(1'b0, 4'h6, 1'b0, 8'h00, rd);
        chk(rd == 8'h60, "R2", "tag 6 load", rd, 8'h60);
        base = log_n;
        access(1'b0, 4'h4, 1'b0, 8'h00, rd);
        chk(rd == 8'h4C, "R9", "queued line data served", rd, 8'h4C);
        chk(log_n == base, "R9", "no memory read on queue hit", log_n, base);
        access(1'b1, 4'h6, 1'b0, 8'h6E, rd);
        access(1'b1, 4'h4, 1'b1, 8'h4F, rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = {4'h7, 1'b0};
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cpu_done) seen = 1'b1;
        end
        chk(seen == 1'b0, "R8", "miss stalls on full queue", seen, 0);
        chk(log_n == base, "R8", "nothing issued while stalled", log_n, base);
        hold_wr = 1'b0;
        do @(negedge clk); while (!cpu_done);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        chk(rd == 8'h70, "R8", "stalled miss completes", rd, 8'h70);
        settle();
        chk_log(base,     1'b1, 4'h4, 16'h414C, "R7");
        chk_log(base + 1, 1'b0, 4'h7, 16'h7170, "R10");
        chk_log(base + 2, 1'b1, 4'h5, 16'h5D50, "R7");
        chk_log(base + 3, 1'b1, 4'h6, 16'h616E, "R8");
        chk(log_n == base + 4, "R7", "transaction count", log_n, base + 4);
    endtask

    task automatic t_refetch();
        logic [7:0] rd;
        int base;
        base = log_n;
        access(1'b0, 4'h5, 1'b1, 8'h00, rd);
        chk(rd == 8'h5D, "R5", "written-back item refetched", rd, 8'h5D);
        settle();
        chk_log(base,     1'b0, 4'h5, 16'h5D50, "R2");
        chk_log(base + 1, 1'b1, 4'h4, 16'h4F4C, "R5");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hits();
        t_replace();
        t_queue();
        t_refetch();
        finish_run();
    end
endmodule